// File: doc/BRIEF.md
# GPIO pin interrupt and alarm unit

The block watches a small input port (eight pins by default) and turns activity on those pins into interrupts. Each pin carries its own three-bit trigger mode, an enable bit in the interrupt mask and a sticky pending bit. Pins first pass through a two-flop synchronizer. A per-pin detector then compares the current synchronized value with the value from one cycle earlier to find levels and edges, and sets the pending bit. Software clears pending bits by writing a word of ones to the acknowledge address. The masked status word and a single interrupt line show which enabled sources are waiting.

Beside the interrupt path sits a level comparator with two accumulating masks. One mask selects pins that should raise the alarm flag when they read 1. The other selects pins that should raise it when they read 0. Commands OR new bits into either mask, and a clear command removes the given bits from both. Configuration, mask, acknowledge and alarm commands all pass through one simple register port. Read data is registered.

Top module: `gpio_irq_unit`

## Requirements
- R1: Each pin passes through a two-flop synchronizer. A value driven on `pin_in` before clock edge k is returned when address 0 is read from edge k+2 onward.
- R2: The mode of pin i is held in bits [3i+2:3i] of the configuration register at address 2. Code 0 (off) and code 7 (reserved) never set a pending bit.
- R3: Code 1 sets pending while the pin is 1, and code 2 sets it while the pin is 0. An acknowledge cannot clear the bit while that level persists. Once set, the bit stays set after the level goes away.
- R4: Code 4 sets pending on a 0-to-1 change of the synchronized pin, code 5 on a 1-to-0 change, and code 6 on either change. No pending bit is set while the pin is steady.
- R5: Code 3 forces the pending bit every cycle. When a set event and an acknowledge meet on the same bit in the same cycle, the bit stays set.
- R6: Writing address 4 clears every pending bit whose write-data bit is 1. A 0 bit leaves the pending bit unchanged. Address 7 reads the raw pending bits.
- R7: Address 1 reads pending AND mask. The mask is read/write at address 3. `irq_o` is the registered OR of the masked status bits.
- R8: A write to address 5 ORs its data into the high-alarm mask, and a write to address 6 ORs its data into the low-alarm mask. Both masks read back at those addresses. A write to address 7 removes the written bits from both masks.
- R9: `alarm_o` is 1 when any synchronized pin selected in the high mask reads 1, or any selected in the low mask reads 0. It is registered one cycle after synchronization.
- R10: After reset, configuration, mask, pending bits, both alarm masks, `irq_o`, `alarm_o` and read data are all 0. Address 4 reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | PIN_W | Asynchronous input pins |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 3*PIN_W | Write data |
| bus_rdata | output | 3*PIN_W | Registered read data of the address presented in the previous cycle |
| irq_o | output | 1 | Interrupt, OR of masked status |
| alarm_o | output | 1 | Alarm comparator flag |

## Verification
The bench sweeps every trigger code across several pin transitions. It checks the pending word once after an acknowledge and once after the transition, so a detector that compared against the raw pin, or let an acknowledge beat a level or forced set, would leave the wrong bits. One run gives every pin a different code, which exposes a misplaced mode field. Partial and all-zero acknowledges show whether zeros wrongly clear bits. An exhaustive sweep of the pins against fixed alarm masks, plus accumulate and clear sequences, catches a comparator that replaces its masks or inverts the low side.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MODE_W = 3;
  localparam int ADDR_W = 3;

  typedef enum logic [MODE_W-1:0] {
    TRIG_OFF   = 3'd0,
    TRIG_HIGH  = 3'd1,
    TRIG_LOW   = 3'd2,
    TRIG_FORCE = 3'd3,
    TRIG_RISE  = 3'd4,
    TRIG_FALL  = 3'd5,
    TRIG_BOTH  = 3'd6,
    TRIG_RSVD  = 3'd7
  } trig_mode_e;

  localparam logic [ADDR_W-1:0] A_PINS   = 3'd0;
  localparam logic [ADDR_W-1:0] A_STATUS = 3'd1;
  localparam logic [ADDR_W-1:0] A_CFG    = 3'd2;
  localparam logic [ADDR_W-1:0] A_MASK   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACK    = 3'd4;
  localparam logic [ADDR_W-1:0] A_HI     = 3'd5;
  localparam logic [ADDR_W-1:0] A_LO     = 3'd6;
  localparam logic [ADDR_W-1:0] A_CLR    = 3'd7;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] dprev
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      dprev <= '0;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      dprev <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]        cur,
  input  logic [W-1:0]        prev,
  input  logic [W*MODE_W-1:0] cfg,
  output logic [W-1:0]        evt
);
  for (genvar g = 0; g < W; g++) begin : g_pin
    always_comb begin
      case (trig_mode_e'(cfg[g*MODE_W +: MODE_W]))
        TRIG_HIGH:  evt[g] = cur[g];
        TRIG_LOW:   evt[g] = ~cur[g];
        TRIG_FORCE: evt[g] = 1'b1;
        TRIG_RISE:  evt[g] = cur[g] & ~prev[g];
        TRIG_FALL:  evt[g] = ~cur[g] & prev[g];
        TRIG_BOTH:  evt[g] = cur[g] ^ prev[g];
        default:    evt[g] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_alarm.sv
module gpio_irq_alarm #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         set_hi,
  input  logic         set_lo,
  input  logic         clr,
  input  logic [W-1:0] bits,
  input  logic [W-1:0] pins,
  output logic [W-1:0] hi_mask,
  output logic [W-1:0] lo_mask,
  output logic         alarm
);
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_mask <= '0;
      lo_mask <= '0;
      alarm   <= 1'b0;
    end else begin
      if (set_hi) hi_mask <= hi_mask | bits;
      else if (clr) hi_mask <= hi_mask & ~bits;
      if (set_lo) lo_mask <= lo_mask | bits;
      else if (clr) lo_mask <= lo_mask & ~bits;
      alarm <= |((pins & hi_mask) | (~pins & lo_mask));
    end
  end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
  import gpio_irq_pkg::*;
#(
  parameter int PIN_W       = 8,
  parameter int SYNC_STAGES = 2,
  localparam int DATA_W     = PIN_W * MODE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PIN_W-1:0]  pin_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              alarm_o
);
  localparam int PAD_W = DATA_W - PIN_W;

  logic [PIN_W-1:0]  pin_s, pin_p, evt, ack;
  logic [DATA_W-1:0] cfg_q;
  logic [PIN_W-1:0]  mask_q, pend_q, hi_mask, lo_mask, status;
  logic [DATA_W-1:0] rd_mux;
  logic              wr_hi, wr_lo, wr_clr;

  gpio_irq_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(pin_in), .dout(pin_s), .dprev(pin_p)
  );

  gpio_irq_detect #(.W(PIN_W)) u_detect (
    .cur(pin_s), .prev(pin_p), .cfg(cfg_q), .evt(evt)
  );

  assign wr_hi  = bus_we && (bus_addr == A_HI);
  assign wr_lo  = bus_we && (bus_addr == A_LO);
  assign wr_clr = bus_we && (bus_addr == A_CLR);

  gpio_irq_alarm #(.W(PIN_W)) u_alarm (
    .clk(clk), .rst(rst), .set_hi(wr_hi), .set_lo(wr_lo), .clr(wr_clr),
    .bits(bus_wdata[PIN_W-1:0]), .pins(pin_s),
    .hi_mask(hi_mask), .lo_mask(lo_mask), .alarm(alarm_o)
  );

  assign ack    = (bus_we && bus_addr == A_ACK) ? bus_wdata[PIN_W-1:0] : '0;
  assign status = pend_q & mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      mask_q <= '0;
      pend_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (bus_we && bus_addr == A_CFG)  cfg_q  <= bus_wdata;
      if (bus_we && bus_addr == A_MASK) mask_q <= bus_wdata[PIN_W-1:0];
      pend_q <= (pend_q & ~ack) | evt;
      irq_o  <= |status;
    end
  end

  always_comb begin
    case (bus_addr)
      A_PINS:   rd_mux = {{PAD_W{1'b0}}, pin_s};
      A_STATUS: rd_mux = {{PAD_W{1'b0}}, status};
      A_CFG:    rd_mux = cfg_q;
      A_MASK:   rd_mux = {{PAD_W{1'b0}}, mask_q};
      A_HI:     rd_mux = {{PAD_W{1'b0}}, hi_mask};
      A_LO:     rd_mux = {{PAD_W{1'b0}}, lo_mask};
      A_CLR:    rd_mux = {{PAD_W{1'b0}}, pend_q};
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
  import gpio_irq_pkg::*;
#(
  parameter int PIN_W = 8
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    bus_we,
  input logic [ADDR_W-1:0]       bus_addr,
  input logic [PIN_W*MODE_W-1:0] bus_wdata,
  input logic [PIN_W*MODE_W-1:0] cfg,
  input logic [PIN_W-1:0]        mask,
  input logic [PIN_W-1:0]        pend,
  input logic                    irq,
  input logic [PIN_W-1:0]        hi_mask,
  input logic [PIN_W-1:0]        lo_mask
);
  logic             armed;
  logic [PIN_W-1:0] off_m, force_m, ack_m, hi_cmd;

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  always_comb begin
    for (int i = 0; i < PIN_W; i++) begin
      off_m[i]   = (cfg[i*MODE_W +: MODE_W] == TRIG_OFF) ||
                   (cfg[i*MODE_W +: MODE_W] == TRIG_RSVD);
      force_m[i] = (cfg[i*MODE_W +: MODE_W] == TRIG_FORCE);
    end
  end

  assign ack_m  = (bus_we && bus_addr == A_ACK) ? bus_wdata[PIN_W-1:0] : '0;
  assign hi_cmd = (bus_we && bus_addr == A_HI)  ? bus_wdata[PIN_W-1:0] : '0;

  // R6: a pending bit falls only where an acknowledge bit was written
  assert_ack_only_clears_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(pend) & ~pend & ~$past(ack_m)) == '0);

  // R2: off and reserved modes never raise a pending bit
  assert_off_never_sets_R2: assert property (@(posedge clk) disable iff (rst || !armed)
    (pend & ~$past(pend) & $past(off_m)) == '0);

  // R5: forced mode keeps the bit pending even against an acknowledge
  assert_force_wins_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(force_m) & ~pend) == '0);

  // R7: the interrupt needs an enabled source one cycle earlier
  assert_irq_needs_mask_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    irq |-> ($past(mask) != '0));

  // R8: set-high command bits are present in the high mask afterwards
  assert_hi_accumulates_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    (hi_cmd != '0) |=> ((hi_mask & $past(hi_cmd)) == $past(hi_cmd)));

  // R8: clear command leaves neither mask holding the cleared bits
  assert_clr_both_R8: assert property (@(posedge clk) disable iff (rst || !armed)
    (bus_we && bus_addr == A_CLR) |=>
      (((hi_mask | lo_mask) & $past(bus_wdata[PIN_W-1:0])) == '0));
endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.PIN_W(PIN_W)) u_chk (
  .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .cfg(cfg_q), .mask(mask_q), .pend(pend_q),
  .irq(irq_o), .hi_mask(hi_mask), .lo_mask(lo_mask)
);

// File: tb/gpio_irq_unit_bench.sv
module gpio_irq_unit_bench;
  localparam int W  = 8;
  localparam int DW = 3 * W;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [W-1:0]  pin_in = '0;
  logic          bus_we = 1'b0;
  logic [2:0]    bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          irq_o, alarm_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  gpio_irq_unit u_gpio_irq_unit (
    .clk(clk), .rst(rst), .pin_in(pin_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .alarm_o(alarm_o)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [DW-1:0] cfg_all(input logic [2:0] m);
    logic [DW-1:0] c;
    for (int i = 0; i < W; i++) c[i*3 +: 3] = m;
    return c;
  endfunction

  function automatic logic [W-1:0] exp_after(input logic [2:0] m, input logic [W-1:0] v0,
                                             input logic [W-1:0] v1, input bit phase_b);
    case (m)
      3'd1: return phase_b ? (v0 | v1) : v0;
      3'd2: return phase_b ? (~v0 | ~v1) : ~v0;
      3'd3: return '1;
      3'd4: return phase_b ? (~v0 & v1) : '0;
      3'd5: return phase_b ? (v0 & ~v1) : '0;
      3'd6: return phase_b ? (v0 ^ v1) : '0;
      default: return '0;
    endcase
  endfunction

  task automatic finish_run;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    logic [DW-1:0] r;
    logic [W-1:0] v0s [5] = '{8'h00, 8'hFF, 8'hA5, 8'h0F, 8'h5A};
    logic [W-1:0] v1s [5] = '{8'hFF, 8'h00, 8'h3C, 8'hF0, 8'h5A};
    logic [W-1:0] hm, lm;

    wait_cyc(4);
    rst = 1'b0;
    // R10 reset state
    check("R10 rdata", bus_rdata, '0);
    check("R10 irq", {23'd0, irq_o}, '0);
    check("R10 alarm", {23'd0, alarm_o}, '0);
    rd(3'd2, r); check("R10 cfg", r, '0);
    rd(3'd3, r); check("R10 mask", r, '0);
    rd(3'd7, r); check("R10 pending", r, '0);
    rd(3'd5, r); check("R10 high mask", r, '0);
    rd(3'd6, r); check("R10 low mask", r, '0);
    rd(3'd4, r); check("R10 ack reads 0", r, '0);

    // R1 synchronized raw read
    pin_in = 8'hC3;
    wait_cyc(3);
    rd(3'd0, r); check("R1 raw pins", r, 24'hC3);

    // R2 R3 R4 R5 R6 R7 sweep over all codes and transitions
    for (int m = 0; m < 8; m++) begin
      for (int k = 0; k < 5; k++) begin
        logic [W-1:0] e;
        wr(3'd2, cfg_all(3'(m)));
        pin_in = v0s[k];
        wait_cyc(5);
        wr(3'd4, {16'd0, 8'hFF});
        wait_cyc(1);
        e = exp_after(3'(m), v0s[k], v1s[k], 1'b0);
        rd(3'd7, r); check($sformatf("R6 R3 R5 pending after ack mode %0d", m), r, {16'd0, e});
        pin_in = v1s[k];
        wait_cyc(5);
        e = exp_after(3'(m), v0s[k], v1s[k], 1'b1);
        rd(3'd7, r); check($sformatf("R2 R4 pending after change mode %0d", m), r, {16'd0, e});
        wr(3'd3, {16'd0, 8'h3C});
        rd(3'd1, r); check("R7 masked status", r, {16'd0, e & 8'h3C});
        check("R7 irq", {23'd0, irq_o}, {23'd0, |(e & 8'h3C)});
      end
    end

    // R2 field position: pin i gets code i
    wr(3'd3, '0);
    pin_in = 8'h00;
    wait_cyc(4);
    begin
      logic [DW-1:0] c;
      for (int i = 0; i < W; i++) c[i*3 +: 3] = 3'(i);
      wr(3'd2, c);
      rd(3'd2, r); check("R2 cfg readback", r, c);
    end
    wait_cyc(2);
    wr(3'd4, {16'd0, 8'hFF});
    pin_in = 8'hFF;
    wait_cyc(5);
    rd(3'd7, r); check("R2 per-pin fields", r, 24'h5E);
    check("R7 irq masked off", {23'd0, irq_o}, '0);

    // R6 zero and partial acknowledge
    wr(3'd2, cfg_all(3'd4));
    pin_in = 8'h00;
    wait_cyc(4);
    wr(3'd4, {16'd0, 8'hFF});
    pin_in = 8'hFF;
    wait_cyc(5);
    wr(3'd4, '0);
    rd(3'd7, r); check("R6 zero ack no effect", r, 24'hFF);
    wr(3'd4, {16'd0, 8'h0F});
    rd(3'd7, r); check("R6 partial ack", r, 24'hF0);
    wr(3'd3, {16'd0, 8'h0F});
    wait_cyc(2);
    check("R7 irq zero when masked out", {23'd0, irq_o}, '0);
    wr(3'd3, {16'd0, 8'h10});
    wait_cyc(2);
    check("R7 irq set", {23'd0, irq_o}, 24'd1);

    // R8 accumulate and clear
    wr(3'd5, {16'd0, 8'h01});
    wr(3'd5, {16'd0, 8'h80});
    rd(3'd5, r); check("R8 high accumulate", r, 24'h81);
    wr(3'd6, {16'd0, 8'h10});
    rd(3'd6, r); check("R8 low mask", r, 24'h10);
    pin_in = 8'h00; wait_cyc(5);
    check("R9 low pin at 0", {23'd0, alarm_o}, 24'd1);
    pin_in = 8'h10; wait_cyc(5);
    check("R9 no alarm", {23'd0, alarm_o}, '0);
    pin_in = 8'h11; wait_cyc(5);
    check("R9 high pin at 1", {23'd0, alarm_o}, 24'd1);
    wr(3'd7, {16'd0, 8'h81});
    rd(3'd5, r); check("R8 clear high", r, '0);
    rd(3'd6, r); check("R8 clear leaves low", r, 24'h10);
    wr(3'd7, {16'd0, 8'h10});
    rd(3'd6, r); check("R8 clear low", r, '0);
    wait_cyc(2);
    check("R9 masks empty", {23'd0, alarm_o}, '0);

    // R9 exhaustive pin sweep
    hm = 8'h5A; lm = 8'h0F;
    wr(3'd5, {16'd0, hm});
    wr(3'd6, {16'd0, lm});
    for (int p = 0; p < 256; p++) begin
      pin_in = 8'(p);
      wait_cyc(4);
      check($sformatf("R9 sweep pins %02h", p), {23'd0, alarm_o},
            {23'd0, |((8'(p) & hm) | (~8'(p) & lm))});
    end

    finish_run();
  end
endmodule